// File: doc/BRIEF.md
# Multi-channel DMA transfer sequencer

This block sequences byte transfers for a four-channel DMA engine. A peripheral raises a channel request. The sequencer asks the host for the bus with a hold request and waits for the host to grant it. It then runs address and transfer cycles for the chosen channel. It steps that channel's current address up and its current count down after every byte. It gives the bus back when a byte rule, terminal count or an external end-of-process input says the transfer is over.

The starting address and count of each channel arrive on input ports and are copied into the working registers by a load pulse. The mode of each channel also arrives on input ports. The outgoing 16-bit address is split. The low byte sits on a dedicated address output. The high byte is placed on the shared data output during a strobe cycle. A memory-to-memory option pairs channel 0, which supplies the source address, with channel 1, which supplies the destination address and the count. Each byte is read into a holding register and then written out. The source address can be frozen so that one byte fills a whole region. A channel in cascade mode passes its request straight through to the host and returns the grant as its acknowledge.

Top module: `dma_seq`

## Requirements
- R1: A pending request raises `hold_req` on the next cycle. No `dack` bit and no `adstb` appear until `hold_ack` has been sampled high. The strobe cycle follows the first cycle in which `hold_ack` is high. During that strobe cycle and the transfer cycle after it, `dack` bit i is set for the served channel i.
- R2: Arbitration happens only in the idle state while `hold_ack` is low. The lowest-numbered pending channel wins, and a channel whose `mask` bit is 1 is ignored.
- R3: In single mode (mode code 0), exactly one byte moves per service. After that byte `hold_req` drops.
- R4: In block mode (mode code 1), bytes continue without releasing the bus until the count passes from 0 to all-ones. A loaded count of N-1 therefore moves N bytes.
- R5: When `eop_in` is high during a byte's transfer cycle, the transfer ends after that byte. `eop_out` pulses only if that byte was also the terminal-count byte.
- R6: In demand mode (mode code 2), the bus is released after the current byte whenever the channel's request is low. A later request resumes from the stored address and count.
- R7: In cascade mode (mode code 3), `hold_req` follows the channel's request, and `dack` bit i equals `hold_ack` while the request is high. The channel drives no address, no strobe and no data.
- R8: When `m2m_en` is 1, a request on channel 0 runs copy cycles in this order: a source strobe and a `bus_rd` cycle that latches `data_in`, then a destination strobe and a `bus_wr` cycle that drives the latched byte. No `dack` bit is asserted. Channel 1's count decides terminal count, and channel 1's own request is ignored.
- R9: With `src_hold` at 1 during copy cycles, the source address stays at channel 0's loaded value. The destination address still increments.
- R10: In a strobe cycle `adstb` is 1, `data_out` carries address bits 15:8 and `addr_lo` carries bits 7:0. The address rises by one per byte, and a carry crosses into the high byte.
- R11: `eop_out` is high for exactly one cycle, the cycle after the terminal-count byte. A channel that reached terminal count is not served again until `load` is pulsed.
- R12: After reset, `hold_req`, `dack`, `adstb`, `data_oe` and `eop_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 4 | Per-channel transfer request |
| mask | input | 4 | Per-channel request mask, 1 ignores the channel |
| ch_mode | input | 8 | Two-bit mode per channel, channel i at bits 2i+1:2i |
| base_addr | input | 64 | Start address per channel, channel i at bits 16i+15:16i |
| base_cnt | input | 64 | Start count per channel (bytes minus one) |
| load | input | 1 | Copies start address and count into the working registers |
| m2m_en | input | 1 | Enables memory-to-memory copy on channels 0 and 1 |
| src_hold | input | 1 | Freezes the copy source address |
| eop_in | input | 1 | External end-of-process |
| hold_req | output | 1 | Bus hold request to the host |
| hold_ack | input | 1 | Bus grant from the host |
| dack | output | 4 | Per-channel acknowledge |
| addr_lo | output | 8 | Address bits 7:0 |
| data_out | output | 8 | High address byte during strobe, write data during copy write |
| data_oe | output | 1 | Data output enable |
| data_in | input | 8 | Read data for copy cycles |
| adstb | output | 1 | High-address strobe |
| bus_rd | output | 1 | Copy read cycle |
| bus_wr | output | 1 | Copy write cycle |
| eop_out | output | 1 | Terminal-count pulse |

## Verification
Terminal count and the external end-of-process input can both fire on the same transfer cycle. The bench provokes this by holding `eop_in` high on a channel loaded with a count of zero. A correct result is one byte followed by a single `eop_out` pulse. It also arranges for a demand channel's request to drop while a byte is still in flight. Here a correct result is exactly three bytes with the bus released, and the remaining bytes completing, with the terminal pulse, after the request returns.

// File: rtl/dma_pkg.sv
package dma_pkg;
    localparam int NCH = 4;
    localparam int AW  = 16;
    localparam int BW  = 8;
    localparam int MW  = 2;
    localparam int CW  = $clog2(NCH);

    typedef enum logic [MW-1:0] {
        M_SINGLE  = 2'd0,
        M_BLOCK   = 2'd1,
        M_DEMAND  = 2'd2,
        M_CASCADE = 2'd3
    } xfer_mode_e;

    typedef enum logic [2:0] {
        S_IDLE, S_WAIT, S_ADDR, S_IO, S_RD, S_DADDR, S_WR, S_CASC
    } seq_state_e;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [AW-1:0] cnt;
    } chan_cur_t;

    function automatic logic [NCH-1:0] chan_bit(input logic [CW-1:0] idx);
        logic [NCH-1:0] r;
        r = '0;
        r[idx] = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/dma_chan.sv
module dma_chan
    import dma_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] start_addr,
    input  logic [AW-1:0] start_cnt,
    input  logic          step_addr,
    input  logic          step_cnt,
    output logic [AW-1:0] cur_addr,
    output logic          tc,
    output logic          done
);
    chan_cur_t cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur  <= '0;
            done <= 1'b0;
        end else if (load) begin
            cur  <= '{addr: start_addr, cnt: start_cnt};
            done <= 1'b0;
        end else begin
            if (step_addr) cur.addr <= cur.addr + AW'(1);
            if (step_cnt) begin
                cur.cnt <= cur.cnt - AW'(1);
                if (cur.cnt == '0) done <= 1'b1;
            end
        end
    end

    assign cur_addr = cur.addr;
    assign tc       = (cur.cnt == '0);
endmodule

// File: rtl/dma_arb.sv
module dma_arb
    import dma_pkg::*;
(
    input  logic [NCH-1:0] pend,
    output logic           any,
    output logic [CW-1:0]  gnt
);
    always_comb begin
        any = |pend;
        gnt = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (pend[i]) gnt = CW'(i);
        end
    end
endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NCH-1:0]    req,
    input  logic [NCH-1:0]    mask,
    input  logic [NCH*MW-1:0] ch_mode,
    input  logic [NCH*AW-1:0] base_addr,
    input  logic [NCH*AW-1:0] base_cnt,
    input  logic              load,
    input  logic              m2m_en,
    input  logic              src_hold,
    input  logic              eop_in,
    output logic              hold_req,
    input  logic              hold_ack,
    output logic [NCH-1:0]    dack,
    output logic [BW-1:0]     addr_lo,
    output logic [BW-1:0]     data_out,
    output logic              data_oe,
    input  logic [BW-1:0]     data_in,
    output logic              adstb,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic              eop_out
);
    seq_state_e     state, nxt;
    logic [CW-1:0]  sel, gnt;
    logic           any, m2m_cyc, gnt_m2m;
    logic [BW-1:0]  hold_byte;
    logic           eop_q;
    logic [NCH-1:0] pend, tc, done, step_a, step_c;
    logic [AW-1:0]  ca [NCH];
    logic [AW-1:0]  bus_a;
    xfer_mode_e     sel_mode, gnt_mode;
    logic           io_end, mm_end, driving;

    // per-channel working registers
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        dma_chan u_ch (
            .clk       (clk),
            .rst       (rst),
            .load      (load),
            .start_addr(base_addr[g*AW +: AW]),
            .start_cnt (base_cnt[g*AW +: AW]),
            .step_addr (step_a[g]),
            .step_cnt  (step_c[g]),
            .cur_addr  (ca[g]),
            .tc        (tc[g]),
            .done      (done[g])
        );
        assign step_a[g] = (state == S_IO && sel == CW'(g)) ||
                           (state == S_WR && (g == 1 || (g == 0 && !src_hold)));
        assign step_c[g] = (state == S_IO && sel == CW'(g)) ||
                           (state == S_WR && g == 1);
    end

    // requests eligible for service
    always_comb begin
        pend = req & ~mask & ~done;
        if (m2m_en) begin
            pend[1] = 1'b0;
            pend[0] = req[0] & ~mask[0] & ~done[1];
        end
    end

    dma_arb u_arb (.pend(pend), .any(any), .gnt(gnt));

    assign gnt_m2m  = m2m_en && (gnt == '0);
    assign gnt_mode = xfer_mode_e'(ch_mode[gnt*MW +: MW]);
    assign sel_mode = xfer_mode_e'(ch_mode[sel*MW +: MW]);
    assign io_end   = tc[sel] || eop_in || (sel_mode == M_SINGLE) ||
                      (sel_mode == M_DEMAND && !req[sel]);
    assign mm_end   = tc[1] || eop_in;

    always_comb begin
        nxt = state;
        case (state)
            S_IDLE:  if (any && !hold_ack)
                         nxt = (!gnt_m2m && gnt_mode == M_CASCADE) ? S_CASC : S_WAIT;
            S_WAIT:  if (hold_ack) nxt = S_ADDR;
            S_ADDR:  nxt = m2m_cyc ? S_RD : S_IO;
            S_IO:    nxt = io_end ? S_IDLE : S_ADDR;
            S_RD:    nxt = S_DADDR;
            S_DADDR: nxt = S_WR;
            S_WR:    nxt = mm_end ? S_IDLE : S_ADDR;
            S_CASC:  if (!req[sel]) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            sel       <= '0;
            m2m_cyc   <= 1'b0;
            hold_byte <= '0;
            eop_q     <= 1'b0;
        end else begin
            state <= nxt;
            if (state == S_IDLE) begin
                sel     <= gnt;
                m2m_cyc <= gnt_m2m;
            end
            if (state == S_RD) hold_byte <= data_in;
            eop_q <= (state == S_IO && tc[sel]) || (state == S_WR && tc[1]);
        end
    end

    // bus drive
    always_comb begin
        driving  = (state == S_ADDR) || (state == S_IO) || (state == S_RD) ||
                   (state == S_DADDR) || (state == S_WR);
        hold_req = (state == S_WAIT) || driving || (state == S_CASC && req[sel]);
        dack     = '0;
        if (!m2m_cyc && (state == S_ADDR || state == S_IO)) dack = chan_bit(sel);
        if (state == S_CASC && hold_ack && req[sel])         dack = chan_bit(sel);
        if (state == S_DADDR || state == S_WR) bus_a = ca[1];
        else if (m2m_cyc)                      bus_a = ca[0];
        else                                   bus_a = ca[sel];
        adstb    = (state == S_ADDR) || (state == S_DADDR);
        addr_lo  = driving ? bus_a[BW-1:0] : '0;
        data_out = adstb ? bus_a[AW-1 -: BW] : ((state == S_WR) ? hold_byte : '0);
        data_oe  = adstb || (state == S_WR);
        bus_rd   = (state == S_RD);
        bus_wr   = (state == S_WR);
    end

    assign eop_out = eop_q;
endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk
    import dma_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           hold_req,
    input logic           hold_ack,
    input logic [NCH-1:0] dack,
    input logic           adstb,
    input logic           data_oe,
    input logic           eop_out,
    input logic           bus_rd,
    input logic           bus_wr
);
    a_r1_dack_needs_grant: assert property (@(posedge clk) disable iff (rst)
        (dack != '0) |-> hold_ack);
    a_r1_idle_bus_quiet: assert property (@(posedge clk) disable iff (rst)
        !hold_req |-> (dack == '0 && !adstb && !bus_rd && !bus_wr));
    a_r2_one_ack: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dack));
    a_r10_strobe_drives: assert property (@(posedge clk) disable iff (rst)
        adstb |-> (data_oe && !bus_rd && !bus_wr));
    a_r8_read_then_dest: assert property (@(posedge clk) disable iff (rst)
        bus_rd |=> adstb);
    a_r8_write_no_ack: assert property (@(posedge clk) disable iff (rst)
        bus_wr |-> (dack == '0 && data_oe));
    a_r11_eop_pulse: assert property (@(posedge clk) disable iff (rst)
        eop_out |=> !eop_out);
endmodule

bind dma_seq dma_seq_chk u_chk (
    .clk(clk), .rst(rst), .hold_req(hold_req), .hold_ack(hold_ack),
    .dack(dack), .adstb(adstb), .data_oe(data_oe), .eop_out(eop_out),
    .bus_rd(bus_rd), .bus_wr(bus_wr)
);

// File: tb/tb_dma_seq.sv
`timescale 1ns/1ps
module tb_dma_seq;
    logic        clk = 1'b0, rst = 1'b1;
    logic [3:0]  req = '0, mask = '0;
    logic [7:0]  ch_mode = '0;
    logic [63:0] base_addr = '0, base_cnt = '0;
    logic        load = 1'b0, m2m_en = 1'b0, src_hold = 1'b0, eop_in = 1'b0;
    logic        hold_req, hold_ack = 1'b0, host_en = 1'b1;
    logic [3:0]  dack;
    logic [7:0]  addr_lo, data_out, data_in = '0;
    logic        data_oe, adstb, bus_rd, bus_wr, eop_out;

    int n_chk = 0, n_err = 0;
    int n_byte, n_rd, n_wr, n_eop;
    logic [15:0] first_stb, last_stb;
    logic        got_first;
    logic [3:0]  first_dack;
    logic [7:0]  last_rd_lo, last_wr_lo, last_wdata;

    dma_seq dut (
        .clk(clk), .rst(rst), .req(req), .mask(mask), .ch_mode(ch_mode),
        .base_addr(base_addr), .base_cnt(base_cnt), .load(load),
        .m2m_en(m2m_en), .src_hold(src_hold), .eop_in(eop_in),
        .hold_req(hold_req), .hold_ack(hold_ack), .dack(dack),
        .addr_lo(addr_lo), .data_out(data_out), .data_oe(data_oe),
        .data_in(data_in), .adstb(adstb), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .eop_out(eop_out)
    );

    always #2.5 clk = ~clk;

    // host grants one half-cycle after the request
    always @(negedge clk) hold_ack <= !rst && host_en && hold_req;

    // bus monitor, samples mid-cycle
    always @(negedge clk) begin
        if (!rst) begin
            if (adstb) begin
                last_stb = {data_out, addr_lo};
                if (!got_first) begin first_stb = {data_out, addr_lo}; got_first = 1'b1; end
            end
            if (dack != '0 && !adstb) n_byte++;
            if (dack != '0 && first_dack == '0) first_dack = dack;
            if (bus_rd) begin n_rd++; last_rd_lo = addr_lo; end
            if (bus_wr) begin n_wr++; last_wr_lo = addr_lo; last_wdata = data_out; end
            if (eop_out) n_eop++;
        end
    end

    task automatic tick(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic clr_mon();
        n_byte = 0; n_rd = 0; n_wr = 0; n_eop = 0; got_first = 1'b0;
        first_stb = '0; last_stb = '0; first_dack = '0;
        last_rd_lo = '0; last_wr_lo = '0; last_wdata = '0;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic set_ch(input int ch, input logic [15:0] a, input logic [15:0] c,
                          input logic [1:0] m);
        base_addr[ch*16 +: 16] = a;
        base_cnt[ch*16 +: 16]  = c;
        ch_mode[ch*2 +: 2]     = m;
    endtask

    task automatic load_all();
        load = 1'b1; tick(1); load = 1'b0; tick(1);
    endtask

    task automatic pulse_req(input logic [3:0] r);
        req = r;
        for (int i = 0; i < 20 && !hold_req; i++) tick(1);
        req = '0;
    endtask

    // {channel, start address, start count, expected terminal pulse}
    localparam logic [36:0] VEC [4] = '{
        {4'd0, 16'h1234, 16'h0005, 1'b0},
        {4'd1, 16'hABFF, 16'h0000, 1'b1},
        {4'd2, 16'h00FF, 16'h0003, 1'b0},
        {4'd3, 16'h8001, 16'h0000, 1'b1}
    };

    initial begin
        clr_mon();
        tick(3);
        rst = 1'b0;
        tick(1);
        // R12 reset state
        chk("R12 hold_req", 32'(hold_req), 0);
        chk("R12 dack", 32'(dack), 0);
        chk("R12 adstb", 32'(adstb), 0);
        chk("R12 data_oe", 32'(data_oe), 0);
        chk("R12 eop_out", 32'(eop_out), 0);

        // R3 R10 R11: single-mode vectors
        for (int v = 0; v < 4; v++) begin
            int ch;
            ch = int'(VEC[v][36:33]);
            set_ch(ch, VEC[v][32:17], VEC[v][16:1], 2'd0);
            load_all();
            clr_mon();
            pulse_req(4'(32'(1) << ch));
            tick(8);
            chk("R3 one byte", 32'(n_byte), 1);
            chk("R3 bus released", 32'(hold_req), 0);
            chk("R10 strobe address", 32'(first_stb), 32'(VEC[v][32:17]));
            chk("R1 dack channel", 32'(first_dack), 32'(1) << ch);
            chk("R11 terminal pulse", 32'(n_eop), 32'(VEC[v][0]));
        end

        // R1 handshake with a slow host
        set_ch(2, 16'h5566, 16'h0004, 2'd0);
        load_all();
        host_en = 1'b0;
        req = 4'b0100;
        tick(3);
        chk("R1 hold requested", 32'(hold_req), 1);
        chk("R1 no dack before grant", 32'(dack), 0);
        chk("R1 no strobe before grant", 32'(adstb), 0);
        host_en = 1'b1;
        tick(1);
        chk("R1 strobe after grant", 32'(adstb), 1);
        chk("R1 dack after grant", 32'(dack), 32'h4);
        req = '0;
        tick(8);

        // R4 R10 block mode with carry into the high byte
        set_ch(1, 16'h20FE, 16'h0003, 2'd1);
        load_all();
        clr_mon();
        pulse_req(4'b0010);
        tick(20);
        chk("R4 block byte count", 32'(n_byte), 4);
        chk("R10 carry address", 32'(last_stb), 32'h2101);
        chk("R4 terminal pulse", 32'(n_eop), 1);
        chk("R4 released", 32'(hold_req), 0);
        // R11 exhausted channel ignored
        clr_mon();
        pulse_req(4'b0010);
        tick(4);
        chk("R11 exhausted ignored", 32'(n_byte), 0);
        chk("R11 no hold", 32'(hold_req), 0);

        // R5 external end-of-process
        set_ch(2, 16'h0700, 16'h0009, 2'd1);
        load_all();
        clr_mon();
        eop_in = 1'b1;
        pulse_req(4'b0100);
        tick(10);
        eop_in = 1'b0;
        chk("R5 early end bytes", 32'(n_byte), 1);
        chk("R5 no terminal pulse", 32'(n_eop), 0);
        // R5 with terminal count in the same cycle
        set_ch(2, 16'h0710, 16'h0000, 2'd1);
        load_all();
        clr_mon();
        eop_in = 1'b1;
        pulse_req(4'b0100);
        tick(10);
        eop_in = 1'b0;
        chk("R5 both ends bytes", 32'(n_byte), 1);
        chk("R5 both ends pulse", 32'(n_eop), 1);

        // R6 demand mode suspend and resume
        set_ch(3, 16'h4000, 16'h0009, 2'd2);
        load_all();
        clr_mon();
        req = 4'b1000;
        for (int i = 0; i < 20 && !hold_req; i++) tick(1);
        tick(5);
        req = '0;
        tick(6);
        chk("R6 suspended", 32'(hold_req), 0);
        chk("R6 partial bytes", 32'(n_byte), 3);
        req = 4'b1000;
        tick(40);
        req = '0;
        tick(4);
        chk("R6 total bytes", 32'(n_byte), 10);
        chk("R6 last address", 32'(last_stb), 32'h4009);
        chk("R6 terminal pulse", 32'(n_eop), 1);

        // R2 priority and mask
        set_ch(1, 16'h0100, 16'h0005, 2'd0);
        set_ch(2, 16'h0200, 16'h0005, 2'd0);
        load_all();
        clr_mon();
        pulse_req(4'b0110);
        tick(8);
        chk("R2 lowest wins", 32'(first_dack), 32'h2);
        mask = 4'b0010;
        clr_mon();
        pulse_req(4'b0110);
        tick(8);
        chk("R2 masked skipped", 32'(first_dack), 32'h4);
        mask = '0;

        // R7 cascade pass-through
        set_ch(0, 16'h0000, 16'h0005, 2'd3);
        load_all();
        clr_mon();
        req = 4'b0001;
        tick(1);
        chk("R7 hold follows request", 32'(hold_req), 1);
        tick(1);
        chk("R7 dack from grant", 32'(dack), 32'h1);
        chk("R7 no strobe", 32'(adstb), 0);
        chk("R7 no data drive", 32'(data_oe), 0);
        tick(3);
        req = '0;
        tick(1);
        chk("R7 hold drops", 32'(hold_req), 0);
        chk("R7 dack drops", 32'(dack), 0);
        set_ch(0, 16'h0000, 16'h0005, 2'd0);
        tick(4);

        // R8 memory-to-memory copy
        m2m_en = 1'b1;
        data_in = 8'h5A;
        set_ch(0, 16'h1000, 16'h0007, 2'd0);
        set_ch(1, 16'h3000, 16'h0002, 2'd0);
        load_all();
        clr_mon();
        pulse_req(4'b0001);
        tick(30);
        chk("R8 writes", 32'(n_wr), 3);
        chk("R8 reads", 32'(n_rd), 3);
        chk("R8 last source", 32'(last_rd_lo), 32'h02);
        chk("R8 last dest", 32'(last_wr_lo), 32'h02);
        chk("R8 write data", 32'(last_wdata), 32'h5A);
        chk("R8 dest high strobe", 32'(last_stb), 32'h3002);
        chk("R8 no dack", 32'(n_byte), 0);
        chk("R8 terminal pulse", 32'(n_eop), 1);

        // R9 frozen source fill
        src_hold = 1'b1;
        data_in = 8'hC3;
        load_all();
        clr_mon();
        pulse_req(4'b0001);
        tick(30);
        chk("R9 writes", 32'(n_wr), 3);
        chk("R9 source fixed", 32'(last_rd_lo), 32'h00);
        chk("R9 dest moves", 32'(last_wr_lo), 32'h02);
        chk("R9 fill data", 32'(last_wdata), 32'hC3);
        src_hold = 1'b0;
        m2m_en = 1'b0;

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule